// File: doc/BRIEF.md
# Coalescing Write-Collect Buffer

This block sits between a write-through cache and the memory interconnect. Every word the cache writes through is offered on the write-in port, tagged with its word address. The buffer keeps up to sixteen 32-byte lines in a fully associative store. A write to a line that is already held is merged into that entry. A write to a line that is not held takes a free entry. Each entry records which of its eight 32-bit words have been written, so that memory later receives a line write with a word mask that covers only those words.

When every entry is busy and a write misses, the buffer picks a victim entry with a free-running LFSR. It writes that entry out to memory and then accepts the new line into the freed slot. Software ordering points (releases) raise a drain request. The buffer then refuses new writes and pushes every held line to memory. It raises drain-done once nothing is held, nothing is waiting at the output, and memory has acknowledged every line write the block issued.

Top module: `wcb_top`

## Requirements
- R1: After reset, wr_ready is 1, mem_valid is 0 and drain_done is 0.
- R2: A write whose line address (wr_addr[29:3]) matches a held entry merges into that entry without taking a new one. This holds even when all 16 entries are busy: the write is accepted with no stall and causes no memory write.
- R3: When the same word of a held line is written twice, the later data replaces the earlier data in the line sent to memory.
- R4: Writes to up to 16 distinct lines are accepted without stalls and cause no memory traffic.
- R5: A write that misses while all 16 entries are busy is stalled (wr_ready 0). During the stall, exactly one resident line, chosen by the LFSR, is written to memory with its full dirty mask. The new write is then accepted.
- R6: Memory write format: mem_addr is the line address wr_addr[29:3]. The word with index wr_addr[2:0] = i appears at mem_data[32*i+31:32*i]. mem_mask bit i is 1 exactly when word i was written since the entry was allocated, and mem_mask is never 0.
- R7: While drain_req is 1, wr_ready is 0, and every held line is written to memory exactly once.
- R8: drain_done rises only after all held lines have been written and every issued memory write has been acknowledged by a mem_ack pulse (one pulse per write). It returns to 0 after drain_req falls.
- R9: While mem_valid is 1 and mem_ready is 0, mem_valid stays 1 and mem_addr, mem_data and mem_mask hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Word write offered |
| wr_ready | output | 1 | Word write accepted this cycle when high with wr_valid |
| wr_addr | input | 30 | Word address: [29:3] line, [2:0] word in line |
| wr_data | input | 32 | Write data word |
| mem_valid | output | 1 | Line write to memory is valid |
| mem_ready | input | 1 | Memory takes the line write |
| mem_addr | output | 27 | Line address of the memory write |
| mem_data | output | 256 | Line data, word i at bits 32*i+31:32*i |
| mem_mask | output | 8 | Per-word write enables of the line write |
| mem_ack | input | 1 | One pulse per completed memory write |
| drain_req | input | 1 | Release: flush everything, held until drain_done |
| drain_done | output | 1 | Buffer empty and all memory writes acknowledged |

## Verification
Assertions check the following on every cycle:
- a probe address never matches more than one entry;
- each accepted miss grows the occupancy by exactly one;
- the output payload stays stable under back-pressure;
- writes stay blocked during a drain;
- drain-done never shows with an issued line or an unacknowledged write;
- the acknowledgment counter neither wraps nor underflows.

The bench scenarios are needed to show that merged words, overwrites and masks reach memory with the right values. They also show that a full buffer evicts exactly one resident line before it takes a new one, that a hit on a full buffer passes without a stall, and that a drain puts out each held line exactly once and waits for delayed acknowledgments.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
  localparam int DEF_ENTRIES    = 16;
  localparam int DEF_WORD_W     = 32;
  localparam int DEF_LINE_WORDS = 8;

  typedef enum logic [1:0] {
    OUT_IDLE  = 2'd0,
    OUT_EVICT = 2'd1,
    OUT_DRAIN = 2'd2
  } out_src_e;
endpackage

// File: rtl/wcb_lookup.sv
module wcb_lookup #(
  parameter int N     = 16,
  parameter int TAG_W = 27,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]       valid,
  input  logic [N*TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]   probe,
  output logic [N-1:0]       hit_vec,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx,
  output logic               has_free,
  output logic [IDX_W-1:0]   free_idx,
  output logic               any_valid,
  output logic [IDX_W-1:0]   first_idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g*TAG_W +: TAG_W] == probe);
  end

  always_comb begin
    hit       = |hit_vec;
    has_free  = ~&valid;
    any_valid = |valid;
    hit_idx   = '0;
    free_idx  = '0;
    first_idx = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx   = IDX_W'(i);
      if (!valid[i])  free_idx  = IDX_W'(i);
      if (valid[i])   first_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/wcb_lfsr.sv
module wcb_lfsr #(
  parameter int             W     = 16,
  parameter logic [W-1:0]   TAPS  = 16'hB400,
  parameter int             IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  output logic [IDX_W-1:0] idx
);
  logic [W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst) state_q <= W'(1);
    else     state_q <= (state_q >> 1) ^ (state_q[0] ? TAPS : '0);
  end

  assign idx = state_q[IDX_W-1:0];

  // R5: the victim source must never lock up at zero
  assert_lfsr_live_R5: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);
endmodule

// File: rtl/wcb_inflight.sv
module wcb_inflight #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  input  logic ack,
  output logic idle
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (issue && !ack) cnt_q <= cnt_q + 1'b1;
    else if (ack && !issue) cnt_q <= cnt_q - 1'b1;
  end

  assign idle = (cnt_q == '0);

  // R8: outstanding-write count must neither wrap nor go below zero
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (issue && !ack) |-> (cnt_q != {CNT_W{1'b1}}));
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    ack |-> (cnt_q != '0));
endmodule

// File: rtl/wcb_top.sv
module wcb_top
  import wcb_pkg::*;
#(
  parameter int         N          = DEF_ENTRIES,
  parameter int         WORD_W     = DEF_WORD_W,
  parameter int         LINE_WORDS = DEF_LINE_WORDS,
  parameter int         WADDR_W    = 30,
  parameter int         CNT_W      = 8,
  parameter int         LFSR_W     = 16,
  parameter logic [15:0] LFSR_TAPS = 16'hB400,
  localparam int IDX_W  = $clog2(N),
  localparam int WIDX_W = $clog2(LINE_WORDS),
  localparam int TAG_W  = WADDR_W - WIDX_W,
  localparam int LINE_W = WORD_W * LINE_WORDS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic [WADDR_W-1:0]    wr_addr,
  input  logic [WORD_W-1:0]     wr_data,
  output logic                  mem_valid,
  input  logic                  mem_ready,
  output logic [TAG_W-1:0]      mem_addr,
  output logic [LINE_W-1:0]     mem_data,
  output logic [LINE_WORDS-1:0] mem_mask,
  input  logic                  mem_ack,
  input  logic                  drain_req,
  output logic                  drain_done
);
  // entry storage: control bits reset, payload arrays left unreset
  logic [N-1:0]          valid_q;
  logic [TAG_W-1:0]      tag_q   [N];
  logic [LINE_WORDS-1:0] dirty_q [N];
  logic [LINE_W-1:0]     line_q  [N];
  logic [N*TAG_W-1:0]    tags_flat;

  for (genvar g = 0; g < N; g++) begin : g_flat
    assign tags_flat[g*TAG_W +: TAG_W] = tag_q[g];
  end

  logic [TAG_W-1:0]  wr_tag;
  logic [WIDX_W-1:0] wr_word;
  assign wr_tag  = wr_addr[WADDR_W-1:WIDX_W];
  assign wr_word = wr_addr[WIDX_W-1:0];

  logic [N-1:0]     hit_vec;
  logic             hit, has_free, any_valid;
  logic [IDX_W-1:0] hit_idx, free_idx, first_idx, victim_idx;

  wcb_lookup #(.N(N), .TAG_W(TAG_W)) u_lookup (
    .valid(valid_q), .tags(tags_flat), .probe(wr_tag),
    .hit_vec(hit_vec), .hit(hit), .hit_idx(hit_idx),
    .has_free(has_free), .free_idx(free_idx),
    .any_valid(any_valid), .first_idx(first_idx)
  );

  wcb_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS[LFSR_W-1:0]), .IDX_W(IDX_W)) u_lfsr (
    .clk(clk), .rst(rst), .idx(victim_idx)
  );

  logic mem_valid_q, issue, idle;
  assign issue = mem_valid_q && mem_ready;

  wcb_inflight #(.CNT_W(CNT_W)) u_inflight (
    .clk(clk), .rst(rst), .issue(issue), .ack(mem_ack), .idle(idle)
  );

  // write acceptance and output-slot selection
  out_src_e              out_src;
  logic                  out_load, wr_fire, miss_full;
  logic [IDX_W-1:0]      out_idx, alloc_idx;
  logic [LINE_WORDS-1:0] word_bit;

  always_comb begin
    miss_full = wr_valid && !hit && !has_free;
    if (drain_req)      out_src = any_valid ? OUT_DRAIN : OUT_IDLE;
    else if (miss_full) out_src = OUT_EVICT;
    else                out_src = OUT_IDLE;
    out_idx   = (out_src == OUT_DRAIN) ? first_idx : victim_idx;
    out_load  = (out_src != OUT_IDLE) && (!mem_valid_q || mem_ready);
    wr_ready  = !drain_req && (hit || has_free);
    wr_fire   = wr_valid && wr_ready;
    alloc_idx = hit ? hit_idx : free_idx;
    word_bit  = LINE_WORDS'(1) << wr_word;
  end

  // control state
  logic drain_done_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q      <= '0;
      mem_valid_q  <= 1'b0;
      drain_done_q <= 1'b0;
    end else begin
      if (out_load) valid_q[out_idx]   <= 1'b0;
      if (wr_fire)  valid_q[alloc_idx] <= 1'b1;
      if (out_load)       mem_valid_q <= 1'b1;
      else if (mem_ready) mem_valid_q <= 1'b0;
      drain_done_q <= drain_req && !any_valid && !mem_valid_q && idle;
    end
  end

  // entry payload (no reset, one word lane written per cycle)
  always_ff @(posedge clk) begin
    if (wr_fire) begin
      tag_q[alloc_idx]   <= wr_tag;
      dirty_q[alloc_idx] <= hit ? (dirty_q[alloc_idx] | word_bit) : word_bit;
      line_q[alloc_idx][wr_word*WORD_W +: WORD_W] <= wr_data;
    end
  end

  // registered memory output payload
  logic [TAG_W-1:0]      mem_addr_q;
  logic [LINE_W-1:0]     mem_data_q;
  logic [LINE_WORDS-1:0] mem_mask_q;
  always_ff @(posedge clk) begin
    if (out_load) begin
      mem_addr_q <= tag_q[out_idx];
      mem_data_q <= line_q[out_idx];
      mem_mask_q <= dirty_q[out_idx];
    end
  end

  assign mem_valid  = mem_valid_q;
  assign mem_addr   = mem_addr_q;
  assign mem_data   = mem_data_q;
  assign mem_mask   = mem_mask_q;
  assign drain_done = drain_done_q;

  // R2: a probe never matches two entries
  assert_hit_unique_R2: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> $onehot0(hit_vec));
  // R4: an accepted miss occupies exactly one more entry
  assert_alloc_grows_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && !hit) |=> ($countones(valid_q) == $past($countones(valid_q)) + 1));
  // R6: a line write always carries at least one word
  assert_mask_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    mem_valid_q |-> (mem_mask_q != '0));
  // R7: writes are blocked while draining
  assert_drain_stall_R7: assert property (@(posedge clk) disable iff (rst)
    drain_req |-> !wr_ready);
  // R8: done only with nothing issued and nothing unacknowledged
  assert_done_clean_R8: assert property (@(posedge clk) disable iff (rst)
    drain_done_q |-> (!mem_valid_q && idle));
  // R9: payload holds under back-pressure
  assert_out_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_valid_q && !mem_ready) |=> (mem_valid_q && $stable(mem_addr_q)
                                     && $stable(mem_data_q) && $stable(mem_mask_q)));
endmodule

// File: tb/wcb_top_tb.sv
`timescale 1ns/1ps
module wcb_top_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst, wr_valid, wr_ready, mem_valid, mem_ready, mem_ack;
  logic         drain_req, drain_done;
  logic [29:0]  wr_addr;
  logic [31:0]  wr_data;
  logic [26:0]  mem_addr;
  logic [255:0] mem_data;
  logic [7:0]   mem_mask;

  wcb_top u_dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_mask(mem_mask), .mem_ack(mem_ack), .drain_req(drain_req),
    .drain_done(drain_done)
  );

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: log accepted writes, ack each one 4 cycles later
  logic [26:0]  log_addr [64];
  logic [7:0]   log_mask [64];
  logic [255:0] log_data [64];
  int  log_n = 0, acks_seen = 0, bad_done = 0, bad_hold = 0;
  logic [3:0] ack_pipe = '0;
  bit  bp_mode = 0;
  int  bp_cnt = 0;
  bit  hold_p = 0;
  logic [26:0] h_addr; logic [255:0] h_data; logic [7:0] h_mask;

  assign mem_ack = ack_pipe[3];

  always @(posedge clk) begin
    bp_cnt <= bp_cnt + 1;
    mem_ready <= bp_mode ? (bp_cnt % 4 == 3) : 1'b1;
  end

  always @(negedge clk) begin
    if (rst) begin
      ack_pipe <= '0;
      hold_p = 0;
    end else begin
      if (drain_done && acks_seen != log_n) bad_done++;
      if (hold_p && !(mem_valid && mem_addr == h_addr && mem_data == h_data
                      && mem_mask == h_mask)) bad_hold++;
      hold_p = mem_valid && !mem_ready;
      h_addr = mem_addr; h_data = mem_data; h_mask = mem_mask;
      if (mem_ack) acks_seen++;
      if (mem_valid && mem_ready && log_n < 64) begin
        log_addr[log_n] = mem_addr; log_mask[log_n] = mem_mask;
        log_data[log_n] = mem_data; log_n++;
      end
      ack_pipe <= {ack_pipe[2:0], mem_valid && mem_ready};
    end
  end

  task automatic wr(input logic [26:0] line, input int w, input logic [31:0] d,
                    output int stalls);
    stalls = 0;
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = {line, 3'(w)}; wr_data = d;
    #1;
    while (!wr_ready) begin @(negedge clk); #1; stalls++; end
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic do_drain(output bit reached);
    bit leak = 0;
    int cyc = 0;
    @(negedge clk); drain_req = 1'b1;
    #1;
    while (!drain_done && cyc < 2000) begin
      if (wr_ready) leak = 1;
      @(negedge clk); #1; cyc++;
    end
    reached = drain_done;
    chk(!leak, "R7 wr_ready low during drain", leak, 0);
    chk(acks_seen == log_n, "R8 all acks in at done", acks_seen, log_n);
    drain_req = 1'b0;
    @(negedge clk); @(negedge clk); #1;
    chk(drain_done == 1'b0, "R8 done drops after release", drain_done, 0);
  endtask

  function automatic logic [31:0] wd(input logic [255:0] v, input int i);
    return v[i*32 +: 32];
  endfunction

  task automatic t_reset();
    @(negedge clk); #1;
    chk(wr_ready == 1'b1, "R1 wr_ready after reset", wr_ready, 1);
    chk(mem_valid == 1'b0, "R1 mem_valid after reset", mem_valid, 0);
    chk(drain_done == 1'b0, "R1 drain_done after reset", drain_done, 0);
  endtask

  task automatic t_merge();
    int s, base; bit ok;
    base = log_n;
    wr(27'h0ABC, 1, 32'h1111_0001, s);
    wr(27'h0ABC, 5, 32'h5555_0005, s);
    wr(27'h0ABC, 1, 32'h2222_0001, s);
    repeat (3) @(negedge clk);
    chk(log_n == base, "R2 merge causes no memory write", log_n, base);
    do_drain(ok);
    chk(ok, "R8 drain_done reached (merge)", ok, 1);
    chk(log_n == base + 1, "R2 merged line written once", log_n - base, 1);
    chk(log_addr[base] == 27'h0ABC, "R6 line address", log_addr[base], 27'h0ABC);
    chk(log_mask[base] == 8'h22, "R6 dirty mask", log_mask[base], 8'h22);
    chk(wd(log_data[base], 5) == 32'h5555_0005, "R6 word 5 lane",
        wd(log_data[base], 5), 32'h5555_0005);
    chk(wd(log_data[base], 1) == 32'h2222_0001, "R3 overwrite keeps last",
        wd(log_data[base], 1), 32'h2222_0001);
  endtask

  task automatic t_fill_evict();
    int s, tot, base, v, hl, cnt;
    bit ok, seen_new, good;
    bit [16:0] seen;
    base = log_n; tot = 0;
    for (int i = 0; i < 16; i++) begin
      wr(27'h100 + 27'(i), i % 8, 32'hA000_0000 + i, s); tot += s;
    end
    repeat (3) @(negedge clk);
    chk(tot == 0, "R4 16 lines without stall", tot, 0);
    chk(log_n == base, "R4 no memory traffic while filling", log_n, base);
    wr(27'h200, 3, 32'hBEEF_0003, s);
    chk(s > 0, "R5 miss on full buffer stalls", s, 1);
    @(negedge clk);
    chk(log_n == base + 1, "R5 exactly one victim written", log_n - base, 1);
    v = int'(log_addr[base]) - 'h100;
    good = (v >= 0 && v < 16) && log_mask[base] == (8'h1 << (v % 8))
           && wd(log_data[base], v % 8) == 32'hA000_0000 + v;
    chk(good, "R5 victim is a resident line with its mask", log_addr[base], 27'h100);
    // hit while full (buffer holds 15 old lines plus the new one)
    hl = (v == 0) ? 1 : 0;
    wr(27'h100 + 27'(hl), (hl + 1) % 8, 32'hC0DE_0000, s);
    chk(s == 0, "R2 hit on full buffer is not stalled", s, 0);
    @(negedge clk);
    chk(log_n == base + 1, "R2 hit on full buffer no eviction", log_n - base, 1);
    do_drain(ok);
    chk(ok, "R8 drain_done reached (full)", ok, 1);
    chk(log_n == base + 17, "R7 drain writes all 16 lines", log_n - base, 17);
    seen = '0; good = 1; seen_new = 0; cnt = 0;
    for (int k = base + 1; k < log_n; k++) begin
      if (log_addr[k] == 27'h200) begin
        if (seen_new || log_mask[k] != 8'h08 || wd(log_data[k], 3) != 32'hBEEF_0003) good = 0;
        seen_new = 1;
      end else begin
        int j = int'(log_addr[k]) - 'h100;
        if (j < 0 || j > 15 || j == v || seen[j]) good = 0;
        else begin
          seen[j] = 1; cnt++;
          if (j == hl) begin
            if (log_mask[k] != ((8'h1 << (j % 8)) | (8'h1 << ((j + 1) % 8)))
                || wd(log_data[k], (j + 1) % 8) != 32'hC0DE_0000) good = 0;
          end else if (log_mask[k] != (8'h1 << (j % 8))) good = 0;
        end
      end
    end
    chk(good && seen_new && cnt == 15, "R7 each held line drained once", cnt, 15);
  endtask

  task automatic t_backpressure();
    int s, base; bit ok;
    base = log_n; bp_mode = 1;
    wr(27'h300, 2, 32'h3333_0002, s);
    wr(27'h301, 7, 32'h7777_0007, s);
    do_drain(ok);
    chk(ok, "R8 drain_done reached (back-pressure)", ok, 1);
    chk(log_n == base + 2, "R7 two lines drained", log_n - base, 2);
    chk(bad_hold == 0, "R9 payload held while not ready", bad_hold, 0);
    chk(log_mask[base] == 8'h04 && wd(log_data[base], 2) == 32'h3333_0002,
        "R6 first line under back-pressure", log_mask[base], 8'h04);
    bp_mode = 0;
  endtask

  task automatic t_drain_empty();
    int base; bit ok;
    base = log_n;
    do_drain(ok);
    chk(ok, "R8 drain of empty buffer completes", ok, 1);
    chk(log_n == base, "R7 empty drain writes nothing", log_n, base);
    chk(bad_done == 0, "R8 done never before all acks", bad_done, 0);
  endtask

  bit timed_out = 0;
  initial begin
    repeat (100000) @(posedge clk);
    timed_out = 1;
  end

  initial begin
    rst = 1'b1; wr_valid = 1'b0; wr_addr = '0; wr_data = '0; drain_req = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    fork
      begin
        t_reset();
        t_merge();
        t_fill_evict();
        t_backpressure();
        t_drain_empty();
      end
      wait (timed_out);
    join_any
    if (timed_out) chk(0, "watchdog expired", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule